// File: doc/BRIEF.md
# SDIO Common Control Register File

This block implements the function-0 common control registers of an SDIO card. A command decoder that has already parsed a single-byte direct I/O access presents it as one strobe carrying an 8-bit offset, a write flag and a data byte. Writes take effect on the next clock edge. Read data is captured on the same edge and held on `rd_data` until the next read.

The block keeps the function enables, the interrupt enables, the bus interface setting, the wide-bus interrupt capability bit, the function-0 block size and the sticky power and speed enable bits. It combines the per-function interrupt request lines into the card interrupt output. That output is held low during a 4-bit data transfer unless interrupts between multi-block transfers are enabled. The abort register produces either a soft-reset pulse or an abort pulse, and the abort pulse is only raised for the function whose transfer is running.

Top module: `sdio_ccr`

## Requirements
- R1: A read of offset 0x00 returns 0x32. A read of offset 0x01 returns 0x02. Offsets 0x09, 0x0A, 0x0B, 0x0E, 0x0F and 0x1C read 0x00.
- R2: A write to offset 0x02 stores the data ANDed with a mask that has bits 1 to `func_count` set (bit i is kept when 1 <= i <= `func_count`). Offsets 0x02 and 0x03 both read the stored value.
- R3: Offset 0x04 reads back the last value written to it. Offset 0x05 reads the request vector `func_req` shifted left by one, so function 1 appears at bit 1 and bit 0 is 0.
- R4: `card_irq` is combinational. It is 0 when bit 0 of the 0x04 register is 0. It is 0 when bits 1:0 of the 0x07 register equal 2, the stored capability bit is 0 and `in_xfer` is 1. In every other case it is 1 exactly when the pending vector from R3 ANDed with the 0x04 register is non-zero.
- R5: A write to offset 0x07 stores (data AND 0xE3) OR 0x40. When data bit 0 is 1, `bus_width_err` pulses high for the one cycle after the write.
- R6: A write to offset 0x06 with data bit 3 set pulses `soft_reset_pulse` for one cycle after the write. On the same edge every writable register (0x02, 0x04, 0x07, the capability bit, 0x10, 0x11 and the sticky bits) becomes zero. In that write no abort pulse is raised, whatever bits 2:0 hold.
- R7: A write to offset 0x06 with bit 3 clear and bits 2:0 non-zero pulses `abort_pulse` for one cycle after the write, but only when `in_xfer` is 1 and bits 2:0 equal `xfer_func`. In every other case no pulse is raised.
- R8: Offset 0x08 reads 0x12 ORed with the stored capability bit at bit 5. A write stores only data bit 5.
- R9: Offsets 0x12 and 0x13 always read with bit 0 set. Bit 1 of each is set by a write with data bit 1 set and stays set until reset, whatever is written afterwards.
- R10: Offset 0x10 is the low byte and offset 0x11 the high byte of the function-0 block size. A write to one leaves the other unchanged. `blk_len0` presents {0x11, 0x10}.
- R11: A read returns its data on `rd_data` in the cycle after the access. A write to a read-only or unmapped offset (for example 0x00, 0x03, 0x0F or 0x40) changes no register, and unmapped offsets read 0x00.
- R12: After hardware reset all writable registers read 0x00 (0x12 and 0x13 read 0x01), all pulse outputs are 0, `card_irq` is 0 and `blk_len0` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Byte access strobe |
| acc_write | input | 1 | 1 for a write access, 0 for a read access |
| acc_addr | input | 8 | Register offset |
| acc_wdata | input | 8 | Write data byte |
| rd_data | output | 8 | Read data, valid the cycle after a read |
| func_count | input | 3 | Number of I/O functions, taken from the operating-condition word |
| func_req | input | NFUNC | Interrupt request lines, one per function starting at function 1 |
| in_xfer | input | 1 | Card is in transfer state (0 means command state) |
| xfer_func | input | 3 | Function number of the running transfer |
| card_irq | output | 1 | Card interrupt output |
| abort_pulse | output | 1 | Ends the running transfer and returns the card to command state |
| soft_reset_pulse | output | 1 | Card soft reset |
| bus_width_err | output | 1 | An illegal bus width was written |
| blk_len0 | output | 16 | Function-0 block size |

## Verification
One write to the abort register can carry both a soft-reset request and an abort field that names the running function. To provoke this, the bench drives `in_xfer` high with `xfer_func` at 2 and writes 0x0A. The write passes only if `soft_reset_pulse` rises, `abort_pulse` stays low, and every writable register afterwards reads zero. The interrupt gate is also tested when two conditions meet in one cycle: the 4-bit bus setting together with `in_xfer` must mask a request that is otherwise enabled, and setting the capability bit must let the same request through.

// File: rtl/sdio_ccr_pkg.sv
package sdio_ccr_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OFS_REV     = 8'h00;
    localparam logic [BYTE_W-1:0] OFS_SPEC    = 8'h01;
    localparam logic [BYTE_W-1:0] OFS_IOEN    = 8'h02;
    localparam logic [BYTE_W-1:0] OFS_IORDY   = 8'h03;
    localparam logic [BYTE_W-1:0] OFS_INTEN   = 8'h04;
    localparam logic [BYTE_W-1:0] OFS_INTPEND = 8'h05;
    localparam logic [BYTE_W-1:0] OFS_ABORT   = 8'h06;
    localparam logic [BYTE_W-1:0] OFS_BUS     = 8'h07;
    localparam logic [BYTE_W-1:0] OFS_CAP     = 8'h08;
    localparam logic [BYTE_W-1:0] OFS_BLKLO   = 8'h10;
    localparam logic [BYTE_W-1:0] OFS_BLKHI   = 8'h11;
    localparam logic [BYTE_W-1:0] OFS_PWR     = 8'h12;
    localparam logic [BYTE_W-1:0] OFS_HS      = 8'h13;

    localparam logic [BYTE_W-1:0] REV_VALUE   = 8'h32;
    localparam logic [BYTE_W-1:0] SPEC_VALUE  = 8'h02;
    localparam logic [BYTE_W-1:0] CAP_BASE    = 8'h12;
    localparam logic [BYTE_W-1:0] BUS_KEEP    = 8'hE3;
    localparam logic [BYTE_W-1:0] BUS_FORCE   = 8'h40;
    localparam int               WIDE_BUS    = 2;

    typedef struct packed {
        logic [BYTE_W-1:0] io_en;
        logic [BYTE_W-1:0] int_en;
        logic [BYTE_W-1:0] bus;
        logic              wide_irq;
        logic [BYTE_W-1:0] blk_lo;
        logic [BYTE_W-1:0] blk_hi;
        logic              pwr_sticky;
        logic              hs_sticky;
        logic [BYTE_W-1:0] rd_data;
        logic              abort;
        logic              sreset;
        logic              bw_err;
    } ccr_state_t;

endpackage

// File: rtl/sdio_ccr_rdmux.sv
module sdio_ccr_rdmux
    import sdio_ccr_pkg::*;
#(
    parameter int NFUNC = 7
) (
    input  logic [BYTE_W-1:0] addr,
    input  ccr_state_t        s_q,
    input  logic [NFUNC-1:0]  func_req,
    output logic [BYTE_W-1:0] rd_value
);
    localparam int PEND_W = NFUNC + 1;

    logic [PEND_W-1:0] pend_vec;
    logic [BYTE_W-1:0] pend_byte;

    assign pend_vec  = {func_req, 1'b0};
    assign pend_byte = BYTE_W'(pend_vec);

    always_comb begin
        case (addr)
            OFS_REV:     rd_value = REV_VALUE;
            OFS_SPEC:    rd_value = SPEC_VALUE;
            OFS_IOEN,
            OFS_IORDY:   rd_value = s_q.io_en;
            OFS_INTEN:   rd_value = s_q.int_en;
            OFS_INTPEND: rd_value = pend_byte;
            OFS_BUS:     rd_value = s_q.bus;
            OFS_CAP:     rd_value = CAP_BASE | {2'b00, s_q.wide_irq, 5'b00000};
            OFS_BLKLO:   rd_value = s_q.blk_lo;
            OFS_BLKHI:   rd_value = s_q.blk_hi;
            OFS_PWR:     rd_value = {6'b000000, s_q.pwr_sticky, 1'b1};
            OFS_HS:      rd_value = {6'b000000, s_q.hs_sticky, 1'b1};
            default:     rd_value = '0;
        endcase
    end
endmodule

// File: rtl/sdio_ccr_irq.sv
module sdio_ccr_irq
    import sdio_ccr_pkg::*;
#(
    parameter int NFUNC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] int_en,
    input  logic [1:0]        bus_width,
    input  logic              wide_irq,
    input  logic              in_xfer,
    input  logic [NFUNC-1:0]  func_req,
    output logic              card_irq
);
    localparam int PEND_W = NFUNC + 1;

    logic [PEND_W-1:0] pend_vec;
    logic [BYTE_W-1:0] pend_byte;
    logic              master_on;
    logic              wide_gate;

    assign pend_vec  = {func_req, 1'b0};
    assign pend_byte = BYTE_W'(pend_vec);
    assign master_on = int_en[0];
    assign wide_gate = (bus_width == 2'(WIDE_BUS)) && !wide_irq && in_xfer;
    assign card_irq  = master_on && !wide_gate && (|(pend_byte & int_en));

    // R4: master enable clear forces the line low
    a_r4_master_off: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en[0] |-> !card_irq);

    // R4: a request with no enabled pending bit never raises the line
    a_r4_no_enabled_request: assert property (@(posedge clk) disable iff (!rst_n)
        ((({func_req, 1'b0}) & int_en[NFUNC:0]) == '0) |-> !card_irq);
endmodule

// File: rtl/sdio_ccr_regs.sv
module sdio_ccr_regs
    import sdio_ccr_pkg::*;
#(
    parameter int NFUNC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [BYTE_W-1:0] acc_addr,
    input  logic [BYTE_W-1:0] acc_wdata,
    input  logic [2:0]        func_count,
    input  logic              in_xfer,
    input  logic [2:0]        xfer_func,
    input  logic [BYTE_W-1:0] rd_value,
    output ccr_state_t        s_q
);
    ccr_state_t        s_d;
    logic [BYTE_W-1:0] io_mask;
    logic              wr_hit;
    logic              sreset_req;

    assign wr_hit     = acc_valid && acc_write;
    assign sreset_req = wr_hit && (acc_addr == OFS_ABORT) && acc_wdata[3];

    always_comb begin
        io_mask = '0;
        for (int i = 1; i <= NFUNC; i++) begin
            if (i <= int'(func_count)) io_mask[i] = 1'b1;
        end
    end

    always_comb begin
        s_d        = s_q;
        s_d.abort  = 1'b0;
        s_d.sreset = 1'b0;
        s_d.bw_err = 1'b0;
        if (acc_valid && !acc_write) s_d.rd_data = rd_value;
        if (wr_hit) begin
            case (acc_addr)
                OFS_IOEN:  s_d.io_en  = acc_wdata & io_mask;
                OFS_INTEN: s_d.int_en = acc_wdata;
                OFS_ABORT: begin
                    if (acc_wdata[3]) begin
                        s_d         = '0;
                        s_d.rd_data = s_q.rd_data;
                        s_d.sreset  = 1'b1;
                    end else if ((acc_wdata[2:0] != 3'd0) && in_xfer &&
                                 (acc_wdata[2:0] == xfer_func)) begin
                        s_d.abort = 1'b1;
                    end
                end
                OFS_BUS: begin
                    s_d.bus    = (acc_wdata & BUS_KEEP) | BUS_FORCE;
                    s_d.bw_err = acc_wdata[0];
                end
                OFS_CAP:   s_d.wide_irq   = acc_wdata[5];
                OFS_BLKLO: s_d.blk_lo     = acc_wdata;
                OFS_BLKHI: s_d.blk_hi     = acc_wdata;
                OFS_PWR:   s_d.pwr_sticky = s_q.pwr_sticky | acc_wdata[1];
                OFS_HS:    s_d.hs_sticky  = s_q.hs_sticky | acc_wdata[1];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: enable bits beyond the function count are never stored
    a_r2_io_en_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && (acc_addr == OFS_IOEN)) |=> ((s_q.io_en & ~$past(io_mask)) == '0));

    // R5: stored bus control always carries the forced bit and no reserved bits
    a_r5_bus_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.bus != '0) |-> (s_q.bus[6] && (s_q.bus[4:2] == 3'b000)));

    // R6: the soft reset pulse coincides with cleared registers
    a_r6_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.sreset |-> ((s_q.io_en == '0) && (s_q.int_en == '0) && (s_q.bus == '0) &&
                        !s_q.wide_irq && (s_q.blk_lo == '0) && (s_q.blk_hi == '0) &&
                        !s_q.pwr_sticky && !s_q.hs_sticky));

    // R6: a soft reset never comes with an abort
    a_r6_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.sreset |-> !s_q.abort);

    // R7: an abort pulse only follows a write made during a transfer
    a_r7_abort_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.abort |-> $past(in_xfer));

    // R9: sticky bits hold unless a soft reset is requested
    a_r9_pwr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pwr_sticky && !sreset_req) |=> s_q.pwr_sticky);
    a_r9_hs_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.hs_sticky && !sreset_req) |=> s_q.hs_sticky);
endmodule

// File: rtl/sdio_ccr.sv
module sdio_ccr
    import sdio_ccr_pkg::*;
#(
    parameter int NFUNC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [7:0]        acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        rd_data,
    input  logic [2:0]        func_count,
    input  logic [NFUNC-1:0]  func_req,
    input  logic              in_xfer,
    input  logic [2:0]        xfer_func,
    output logic              card_irq,
    output logic              abort_pulse,
    output logic              soft_reset_pulse,
    output logic              bus_width_err,
    output logic [15:0]       blk_len0
);
    ccr_state_t        s_q;
    logic [BYTE_W-1:0] rd_value;

    sdio_ccr_regs #(.NFUNC(NFUNC)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_addr   (acc_addr),
        .acc_wdata  (acc_wdata),
        .func_count (func_count),
        .in_xfer    (in_xfer),
        .xfer_func  (xfer_func),
        .rd_value   (rd_value),
        .s_q        (s_q)
    );

    sdio_ccr_rdmux #(.NFUNC(NFUNC)) u_rdmux (
        .addr     (acc_addr),
        .s_q      (s_q),
        .func_req (func_req),
        .rd_value (rd_value)
    );

    sdio_ccr_irq #(.NFUNC(NFUNC)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .int_en    (s_q.int_en),
        .bus_width (s_q.bus[1:0]),
        .wide_irq  (s_q.wide_irq),
        .in_xfer   (in_xfer),
        .func_req  (func_req),
        .card_irq  (card_irq)
    );

    assign rd_data          = s_q.rd_data;
    assign abort_pulse      = s_q.abort;
    assign soft_reset_pulse = s_q.sreset;
    assign bus_width_err    = s_q.bw_err;
    assign blk_len0         = {s_q.blk_hi, s_q.blk_lo};
endmodule

// File: tb/tb_sdio_ccr.sv
`timescale 1ns/1ps
module tb_sdio_ccr;
    localparam int NFUNC = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_valid = 1'b0;
    logic             acc_write = 1'b0;
    logic [7:0]       acc_addr = '0;
    logic [7:0]       acc_wdata = '0;
    logic [7:0]       rd_data;
    logic [2:0]       func_count = 3'd1;
    logic [NFUNC-1:0] func_req = '0;
    logic             in_xfer = 1'b0;
    logic [2:0]       xfer_func = 3'd0;
    logic             card_irq;
    logic             abort_pulse;
    logic             soft_reset_pulse;
    logic             bus_width_err;
    logic [15:0]      blk_len0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdio_ccr #(.NFUNC(NFUNC)) dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
        .func_count(func_count), .func_req(func_req), .in_xfer(in_xfer),
        .xfer_func(xfer_func), .card_irq(card_irq), .abort_pulse(abort_pulse),
        .soft_reset_pulse(soft_reset_pulse), .bus_width_err(bus_width_err),
        .blk_len0(blk_len0)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
        d = rd_data;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, $sformatf("read 0x%h", a), {8'h00, v}, {8'h00, exp});
    endtask

    task automatic t_reset_state;
        rd_check("R12", 8'h02, 8'h00);
        rd_check("R12", 8'h04, 8'h00);
        rd_check("R12", 8'h07, 8'h00);
        rd_check("R12", 8'h12, 8'h01);
        rd_check("R12", 8'h13, 8'h01);
        check("R12", "card_irq", {15'd0, card_irq}, 16'd0);
        check("R12", "blk_len0", blk_len0, 16'h0000);
        check("R12", "pulses", {13'd0, abort_pulse, soft_reset_pulse, bus_width_err}, 16'd0);
    endtask

    task automatic t_constants;
        rd_check("R1", 8'h00, 8'h32);
        rd_check("R1", 8'h01, 8'h02);
        rd_check("R1", 8'h09, 8'h00);
        rd_check("R1", 8'h0A, 8'h00);
        rd_check("R1", 8'h0B, 8'h00);
        rd_check("R1", 8'h0E, 8'h00);
        rd_check("R1", 8'h1C, 8'h00);
    endtask

    task automatic t_io_enable;
        func_count = 3'd1;
        wr(8'h02, 8'hFF);
        rd_check("R2", 8'h02, 8'h02);
        rd_check("R2", 8'h03, 8'h02);
        func_count = 3'd3;
        wr(8'h02, 8'hFF);
        rd_check("R2", 8'h02, 8'h0E);
        func_count = 3'd7;
        wr(8'h02, 8'h55);
        rd_check("R2", 8'h02, 8'h54);
        rd_check("R2", 8'h03, 8'h54);
        func_count = 3'd1;
    endtask

    task automatic t_interrupts;
        wr(8'h04, 8'h03);
        rd_check("R3", 8'h04, 8'h03);
        func_req = 7'b000_0000;
        #1 check("R4", "irq no request", {15'd0, card_irq}, 16'd0);
        func_req = 7'b000_0001;
        #1 check("R4", "irq func1", {15'd0, card_irq}, 16'd1);
        rd_check("R3", 8'h05, 8'h02);
        func_req = 7'b100_0010;
        rd_check("R3", 8'h05, 8'h84);
        #1 check("R4", "irq func2 not enabled", {15'd0, card_irq}, 16'd0);
        func_req = 7'b000_0001;
        wr(8'h04, 8'h02);
        #1 check("R4", "irq master off", {15'd0, card_irq}, 16'd0);
        wr(8'h04, 8'h03);
        in_xfer = 1'b1;
        #1 check("R4", "irq 1-bit bus in transfer", {15'd0, card_irq}, 16'd1);
        wr(8'h07, 8'h02);
        #1 check("R4", "irq masked in 4-bit transfer", {15'd0, card_irq}, 16'd0);
        wr(8'h08, 8'h20);
        #1 check("R4", "irq with wide capability", {15'd0, card_irq}, 16'd1);
        wr(8'h08, 8'h00);
        in_xfer = 1'b0;
        #1 check("R4", "irq 4-bit command state", {15'd0, card_irq}, 16'd1);
        func_req = '0;
        wr(8'h04, 8'h00);
        wr(8'h07, 8'h00);
    endtask

    task automatic t_bus;
        wr(8'hFF == 8'h00 ? 8'h00 : 8'h07, 8'hFF);
        check("R5", "bw_err on bit0", {15'd0, bus_width_err}, 16'd1);
        rd_check("R5", 8'h07, 8'hE3);
        wr(8'h07, 8'h1C);
        check("R5", "no bw_err", {15'd0, bus_width_err}, 16'd0);
        rd_check("R5", 8'h07, 8'h40);
    endtask

    task automatic t_capability;
        rd_check("R8", 8'h08, 8'h12);
        wr(8'h08, 8'hDF);
        rd_check("R8", 8'h08, 8'h12);
        wr(8'h08, 8'h20);
        rd_check("R8", 8'h08, 8'h32);
    endtask

    task automatic t_sticky;
        wr(8'h12, 8'h02);
        rd_check("R9", 8'h12, 8'h03);
        wr(8'h12, 8'h00);
        rd_check("R9", 8'h12, 8'h03);
        wr(8'h13, 8'hFD);
        rd_check("R9", 8'h13, 8'h01);
        wr(8'h13, 8'h02);
        wr(8'h13, 8'h00);
        rd_check("R9", 8'h13, 8'h03);
    endtask

    task automatic t_block_size;
        wr(8'h10, 8'h34);
        wr(8'h11, 8'h12);
        check("R10", "blk_len0", blk_len0, 16'h1234);
        wr(8'h10, 8'hAB);
        check("R10", "low byte only", blk_len0, 16'h12AB);
        rd_check("R10", 8'h11, 8'h12);
        rd_check("R10", 8'h10, 8'hAB);
    endtask

    task automatic t_abort;
        in_xfer = 1'b1;
        xfer_func = 3'd2;
        wr(8'h06, 8'h01);
        check("R7", "mismatched function", {15'd0, abort_pulse}, 16'd0);
        wr(8'h06, 8'h02);
        check("R7", "matching function", {15'd0, abort_pulse}, 16'd1);
        check("R7", "no reset on abort", {15'd0, soft_reset_pulse}, 16'd0);
        @(negedge clk);
        check("R7", "pulse one cycle", {15'd0, abort_pulse}, 16'd0);
        wr(8'h06, 8'h00);
        check("R7", "zero field", {15'd0, abort_pulse}, 16'd0);
        in_xfer = 1'b0;
        wr(8'h06, 8'h02);
        check("R7", "not in transfer", {15'd0, abort_pulse}, 16'd0);
        rd_check("R7", 8'h10, 8'hAB);
    endtask

    task automatic t_soft_reset;
        wr(8'h04, 8'h03);
        wr(8'h02, 8'h02);
        in_xfer = 1'b1;
        xfer_func = 3'd2;
        wr(8'h06, 8'h0A);
        check("R6", "reset pulse", {15'd0, soft_reset_pulse}, 16'd1);
        check("R6", "reset beats abort", {15'd0, abort_pulse}, 16'd0);
        check("R6", "blk_len0 cleared", blk_len0, 16'h0000);
        in_xfer = 1'b0;
        rd_check("R6", 8'h02, 8'h00);
        rd_check("R6", 8'h04, 8'h00);
        rd_check("R6", 8'h07, 8'h00);
        rd_check("R6", 8'h08, 8'h12);
        rd_check("R6", 8'h12, 8'h01);
        rd_check("R6", 8'h13, 8'h01);
    endtask

    task automatic t_ignored;
        wr(8'h02, 8'h02);
        wr(8'h03, 8'h00);
        rd_check("R11", 8'h02, 8'h02);
        wr(8'h40, 8'hFF);
        rd_check("R11", 8'h40, 8'h00);
        wr(8'h0F, 8'hFF);
        rd_check("R11", 8'h0F, 8'h00);
        wr(8'h00, 8'h00);
        rd_check("R11", 8'h00, 8'h32);
        @(negedge clk);
        check("R11", "read data held", {8'h00, rd_data}, 16'h0032);
        check("R11", "blk_len0 untouched", blk_len0, 16'h0000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_constants();
        t_io_enable();
        t_interrupts();
        t_bus();
        t_capability();
        t_sticky();
        t_block_size();
        t_abort();
        t_soft_reset();
        t_ignored();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule